// File: doc/BRIEF.md
# Composed 36x36 Pipelined Multiplier

This block multiplies two 36-bit operands and returns the full 72-bit product. It does not use one wide multiplier. Each operand is split into an 18-bit upper half and an 18-bit lower half. Four narrow multipliers form the partial products upper×upper, lower×upper, upper×lower and lower×lower. A shift-and-add stage then sums the four terms into the result.

Each operand has its own sign flag. When the flag is high the operand is read as two's complement; when it is low the operand is read as unsigned. Only the upper half of an operand carries its sign, and every lower half is multiplied as unsigned. The flags are captured together with their operands, so each operand pair keeps its own signedness as it moves down the pipe.

The pipe has three register stages: operand capture, partial-product capture, and the final sum. All three stages advance only on clock edges where the shared enable is high. An asynchronous clear empties all three stages.

Top module: `wmul36_top`

## Requirements
- R1: The product of an operand pair that is present at an enabled clock edge appears on `product` right after the third enabled edge, counting that edge as the first.
- R2: When both sign flags are 0, `product` equals the unsigned product. For example, 36'hF_FFFF_FFFF squared gives 72'hFF_FFFF_FFE0_0000_0001.
- R3: When both sign flags are 1, `product` equals the two's-complement product in 72 bits. For example, the most negative value 36'h8_0000_0000 squared gives 72'h40_0000_0000_0000_0000.
- R4: When exactly one sign flag is 1, only that operand is read as two's complement. For example, `opA` = 1 with `signB` = 1 returns `opB` sign-extended to 72 bits.
- R5: While `clkEn` is 0, no stage changes and `product` holds its value, even if the operands and flags change.
- R6: While `aClr` is 1, `product` is 0 without waiting for a clock edge. Pairs that were in flight are discarded, so the next three enabled edges after release still show 0.
- R7: Changing a sign flag between consecutive pairs changes the result of that pair only. The results of the neighbouring pairs are unaffected.
- R8: An operand of zero gives a product of zero under any combination of sign flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on its rising edge |
| aClr | input | 1 | Asynchronous clear, active high |
| clkEn | input | 1 | Clock enable; when low, every stage holds its contents |
| opA | input | 36 | First operand |
| opB | input | 36 | Second operand |
| signA | input | 1 | 1: `opA` is two's complement; 0: unsigned |
| signB | input | 1 | 1: `opB` is two's complement; 0: unsigned |
| product | output | 72 | Registered 72-bit product |

## Verification
The bench builds the block with its default half width of 18, so the operands are 36 bits and the product is 72 bits. At this width the upper halves reach their most negative and all-ones patterns. That makes the sign-extension corners of each cross term and of the upper×upper term observable at the output. Random pairs run under all four sign-flag combinations, and pairs with alternating flags run back to back. Enable gaps and a clear in mid-stream test the hold behaviour and the flush of in-flight pairs.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

  // Load strobes that the control module sends to the datapath, one per stage.
  typedef struct packed {
    logic ldIn;    // capture operands and sign flags
    logic ldPipe;  // capture partial products
    logic ldOut;   // capture the summed product
  } wmul_stb_t;

  localparam int unsigned NUM_PP = 4;

endpackage

// File: rtl/wmul_ctrl.sv
module wmul_ctrl
  import wmul_pkg::*;
(
  input  logic      clkEn,
  output wmul_stb_t stb
);

  // Every stage moves in lockstep, so the pipe keeps a fixed latency in
  // enabled edges.
  always_comb begin
    stb.ldIn   = clkEn;
    stb.ldPipe = clkEn;
    stb.ldOut  = clkEn;
  end

endmodule

// File: rtl/wmul_datapath.sv
module wmul_datapath
  import wmul_pkg::*;
#(
  parameter int unsigned HALF_W = 18
) (
  input  logic                  clk,
  input  logic                  aClr,
  input  wmul_stb_t             stb,
  input  logic [2*HALF_W-1:0]   opA,
  input  logic [2*HALF_W-1:0]   opB,
  input  logic                  signA,
  input  logic                  signB,
  output logic [4*HALF_W-1:0]   product
);

  localparam int unsigned OP_W   = 2 * HALF_W;
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned PP_W   = 2 * (HALF_W + 1);

  // Stage 1: operands together with their sign flags
  logic [OP_W-1:0] aReg, bReg;
  logic            aSgn, bSgn;

  always_ff @(posedge clk or posedge aClr) begin
    if (aClr) begin
      aReg <= '0;
      bReg <= '0;
      aSgn <= 1'b0;
      bSgn <= 1'b0;
    end else if (stb.ldIn) begin
      aReg <= opA;
      bReg <= opB;
      aSgn <= signA;
      bSgn <= signB;
    end
  end

  // Stage 2: four narrow partial products.
  // Index bit 1 picks the half of A, index bit 0 picks the half of B.
  logic signed [PP_W-1:0]   ppReg  [NUM_PP];
  logic signed [PROD_W-1:0] termSh [NUM_PP];

  for (genvar i = 0; i < NUM_PP; i++) begin : g_pp
    localparam bit          A_HI  = (i / 2) == 1;
    localparam bit          B_HI  = (i % 2) == 1;
    localparam int unsigned SHIFT = (int'(A_HI) + int'(B_HI)) * HALF_W;

    logic signed [HALF_W:0] xa, xb;
    logic signed [PP_W-1:0] ppComb;

    // An upper half is sign-extended by its flag; a lower half is always
    // zero-extended.
    if (A_HI) begin : g_ahi
      assign xa = {aSgn & aReg[OP_W-1], aReg[OP_W-1:HALF_W]};
    end else begin : g_alo
      assign xa = {1'b0, aReg[HALF_W-1:0]};
    end
    if (B_HI) begin : g_bhi
      assign xb = {bSgn & bReg[OP_W-1], bReg[OP_W-1:HALF_W]};
    end else begin : g_blo
      assign xb = {1'b0, bReg[HALF_W-1:0]};
    end

    assign ppComb = xa * xb;

    always_ff @(posedge clk or posedge aClr) begin
      if (aClr)            ppReg[i] <= '0;
      else if (stb.ldPipe) ppReg[i] <= ppComb;
    end

    assign termSh[i] = {{(PROD_W-PP_W){ppReg[i][PP_W-1]}}, ppReg[i]} <<< SHIFT;
  end

  // Stage 3: sum the shifted terms modulo 2^PROD_W
  logic [PROD_W-1:0] sumComb;

  always_comb begin
    sumComb = '0;
    for (int k = 0; k < NUM_PP; k++) sumComb = sumComb + termSh[k];
  end

  always_ff @(posedge clk or posedge aClr) begin
    if (aClr)           product <= '0;
    else if (stb.ldOut) product <= sumComb;
  end

endmodule

// File: rtl/wmul36_top.sv
module wmul36_top
  import wmul_pkg::*;
#(
  parameter int unsigned HALF_W = 18
) (
  input  logic                clk,
  input  logic                aClr,
  input  logic                clkEn,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  input  logic                signA,
  input  logic                signB,
  output logic [4*HALF_W-1:0] product
);

  wmul_stb_t stb;

  wmul_ctrl ctrl_i (
    .clkEn (clkEn),
    .stb   (stb)
  );

  wmul_datapath #(.HALF_W(HALF_W)) dp_i (
    .clk     (clk),
    .aClr    (aClr),
    .stb     (stb),
    .opA     (opA),
    .opB     (opB),
    .signA   (signA),
    .signB   (signB),
    .product (product)
  );

endmodule

// File: rtl/wmul36_chk.sv
module wmul36_chk #(
  parameter int unsigned HALF_W = 18
) (
  input logic                clk,
  input logic                aClr,
  input logic                clkEn,
  input logic [2*HALF_W-1:0] opA,
  input logic [2*HALF_W-1:0] opB,
  input logic                signA,
  input logic                signB,
  input logic [4*HALF_W-1:0] product
);

  localparam int unsigned OP_W   = 2 * HALF_W;
  localparam int unsigned PROD_W = 2 * OP_W;

  // Three-stage shadows of simple facts about each pair, advanced on enable
  logic [2:0]      zeroPipe, unitPipe;
  logic [OP_W-1:0] bShadow [3];
  logic [2:0]      sbShadow;

  always_ff @(posedge clk or posedge aClr) begin
    if (aClr) begin
      zeroPipe <= '0;
      unitPipe <= '0;
      sbShadow <= '0;
      for (int k = 0; k < 3; k++) bShadow[k] <= '0;
    end else if (clkEn) begin
      zeroPipe <= {zeroPipe[1:0], (opA == '0) || (opB == '0)};
      unitPipe <= {unitPipe[1:0], opA == OP_W'(1)};
      sbShadow <= {sbShadow[1:0], signB};
      bShadow[0] <= opB;
      bShadow[1] <= bShadow[0];
      bShadow[2] <= bShadow[1];
    end
  end

  logic [PROD_W-1:0] unitExp;
  assign unitExp = sbShadow[2] ? {{OP_W{bShadow[2][OP_W-1]}}, bShadow[2]}
                               : {{OP_W{1'b0}}, bShadow[2]};

  // R5: a cycle with the enable low leaves the product unchanged
  assert_hold_R5: assert property (@(posedge clk) disable iff (aClr)
    !clkEn |=> $stable(product));

  // R6: the product reads zero whenever the clear is applied
  assert_clear_R6: assert property (@(posedge clk)
    aClr |-> (product == '0));

  // R8: a zero operand produces a zero product
  assert_zero_R8: assert property (@(posedge clk) disable iff (aClr)
    zeroPipe[2] |-> (product == '0));

  // R4: with opA equal to one, the product is opB extended by its own flag
  assert_unit_R4: assert property (@(posedge clk) disable iff (aClr)
    unitPipe[2] |-> (product == unitExp));

endmodule

bind wmul36_top wmul36_chk #(.HALF_W(HALF_W)) chk_i (
  .clk     (clk),
  .aClr    (aClr),
  .clkEn   (clkEn),
  .opA     (opA),
  .opB     (opB),
  .signA   (signA),
  .signB   (signB),
  .product (product)
);

// File: tb/wmul36_tb_top.sv
`timescale 1ns/1ps
module wmul36_tb_top;

  localparam int unsigned HALF_W = 18;
  localparam int unsigned OP_W   = 2 * HALF_W;
  localparam int unsigned PROD_W = 2 * OP_W;

  logic              clk = 1'b0;
  logic              aClr = 1'b1;
  logic              clkEn = 1'b0;
  logic [OP_W-1:0]   opA = '0, opB = '0;
  logic              signA = 1'b0, signB = 1'b0;
  logic [PROD_W-1:0] product;

  int    testCount = 0;
  int    failCount = 0;
  bit    checking  = 1'b0;
  bit    done      = 1'b0;
  string curReq    = "R1";

  always #5 clk = ~clk;

  wmul36_top #(.HALF_W(HALF_W)) dut_i (
    .clk     (clk),
    .aClr    (aClr),
    .clkEn   (clkEn),
    .opA     (opA),
    .opB     (opB),
    .signA   (signA),
    .signB   (signB),
    .product (product)
  );

  // Exact product of the operands, read through the sign flags, kept to 72 bits
  function automatic logic [PROD_W-1:0] refMul(logic [OP_W-1:0] a, logic [OP_W-1:0] b,
                                               logic sa, logic sb);
    logic signed [PROD_W+1:0] ea, eb, p;
    ea = sa ? {{(OP_W+2){a[OP_W-1]}}, a} : {{(OP_W+2){1'b0}}, a};
    eb = sb ? {{(OP_W+2){b[OP_W-1]}}, b} : {{(OP_W+2){1'b0}}, b};
    p  = ea * eb;
    return p[PROD_W-1:0];
  endfunction

  // Behavioural model: a queue of expected products, advanced on enabled edges
  logic [PROD_W-1:0] expQ[$] = '{'0, '0, '0};

  always @(posedge clk or posedge aClr) begin
    if (aClr) begin
      expQ = '{'0, '0, '0};
    end else if (clkEn) begin
      expQ.push_back(refMul(opA, opB, signA, signB));
      void'(expQ.pop_front());
    end
  end

  task automatic check(string req, logic [PROD_W-1:0] act, logic [PROD_W-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: product=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (checking) check(curReq, product, expQ[0]);
  end

  task automatic drive(logic [OP_W-1:0] a, logic [OP_W-1:0] b, logic sa, logic sb,
                       logic en = 1'b1);
    @(negedge clk);
    opA = a; opB = b; signA = sa; signB = sb; clkEn = en;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) drive('0, '0, 1'b0, 1'b0);
  endtask

  localparam logic [OP_W-1:0] ONES   = '1;
  localparam logic [OP_W-1:0] MOSTNEG = {1'b1, {(OP_W-1){1'b0}}};

  initial begin
    logic [PROD_W-1:0] held;
    #12;
    // R6: reset state
    check("R6", product, '0);
    aClr = 1'b0;
    checking = 1'b1;

    // R1: a single pair shows exactly after the third enabled edge
    curReq = "R1";
    drive(36'd12345, 36'd678, 1'b0, 1'b0);
    drive('0, '0, 1'b0, 1'b0);
    drive('0, '0, 1'b0, 1'b0);
    @(negedge clk);
    check("R1", product, 72'd8369910);

    // R2: unsigned x unsigned
    curReq = "R2";
    drive(ONES, ONES, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) drive(OP_W'({$urandom, $urandom}), OP_W'({$urandom, $urandom}), 1'b0, 1'b0);
    // R3: signed x signed, including the most negative value squared
    curReq = "R3";
    drive(MOSTNEG, MOSTNEG, 1'b1, 1'b1);
    drive(ONES, MOSTNEG, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) drive(OP_W'({$urandom, $urandom}), OP_W'({$urandom, $urandom}), 1'b1, 1'b1);
    // R4: mixed signedness
    curReq = "R4";
    drive(ONES, ONES, 1'b0, 1'b1);
    drive(MOSTNEG, ONES, 1'b1, 1'b0);
    drive(36'd1, MOSTNEG, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) drive(OP_W'({$urandom, $urandom}), OP_W'({$urandom, $urandom}), i[0], ~i[0]);
    // R8: zero operands under all flag combinations
    curReq = "R8";
    for (int i = 0; i < 4; i++) drive('0, ONES, i[0], i[1]);
    for (int i = 0; i < 4; i++) drive(MOSTNEG, '0, i[0], i[1]);
    flush();

    // Direct corner values, independent of the model
    drive(ONES, ONES, 1'b0, 1'b0);
    drive(MOSTNEG, MOSTNEG, 1'b1, 1'b1);
    drive(ONES, ONES, 1'b0, 1'b1);
    @(negedge clk);
    check("R2", product, 72'hFF_FFFF_FFE0_0000_0001);
    @(negedge clk);
    check("R3", product, 72'h40_0000_0000_0000_0000);
    @(negedge clk);
    check("R4", product, 72'hFF_FFFF_FFF0_0000_0001);

    // R7: same operands, flags alternate between back-to-back pairs
    curReq = "R7";
    for (int i = 0; i < 8; i++) drive(ONES, MOSTNEG, i[0], i[1]);
    flush();

    // R5: enable gaps while the inputs keep changing
    curReq = "R5";
    drive(36'd7, 36'd9, 1'b0, 1'b0);
    drive(ONES, 36'd3, 1'b1, 1'b0);
    drive(36'd5, ONES, 1'b0, 1'b1);
    drive(36'd11, 36'd13, 1'b0, 1'b0, 1'b0);
    held = product;
    for (int i = 0; i < 5; i++) drive(OP_W'({$urandom, $urandom}), ONES, 1'b1, 1'b1, 1'b0);
    check("R5", product, held);
    for (int i = 0; i < 4; i++) drive(36'd2, 36'd21, 1'b0, 1'b0);

    // R6: clear in mid-stream, away from the clock edges
    curReq = "R6";
    drive(ONES, ONES, 1'b1, 1'b0);
    drive(36'd99, 36'd3, 1'b0, 1'b0);
    #2 aClr = 1'b1;
    #1 check("R6", product, '0);
    #1 aClr = 1'b0;
    for (int i = 0; i < 3; i++) drive('0, '0, 1'b0, 1'b0);
    flush();

    checking = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule